// File: doc/BRIEF.md
# SCSI Host Register and Interrupt Block

This block is the processor-facing register file of a simple SCSI bus interface controller. A host reads and writes 16-bit registers at byte offsets that are multiples of four. Each register keeps only the bits it defines. The two status registers combine three kinds of bit: read-only, write-one-to-clear, and plain read/write. A command register starts disconnect, select and programmed-I/O transfer actions. These actions update the status registers without further help from software.

The bus-side engine is outside this block. It reports events as one-cycle strobes: set masks for either status register, and a pulse meaning a selection was won. Every cycle the block recomputes a connection summary bit and a data summary bit and writes both into both status registers. A level-sensitive interrupt line follows those summaries, gated by an enable bit in the control register. A prescaled free-running counter occupies the low bits of the data-status register. Because the transfer command compares its phase bits against that counter, a pending transfer waits until the phases line up.

Top module: `scsi_host_regs`

## Requirements
- R1: Registers sit at byte offsets 0x00 diag, 0x0C control, 0x10 own-ID, 0x14 target-ID, 0x18 detect-status, 0x20 data, 0x24 sync-mode, 0x48 connection-status, 0x4C data-status, 0x50 command, 0x54 diag-control. A read returns the register value on `host_rdata` one cycle after the read strobe. Unmapped offsets read as zero and ignore writes. An access whose address has bit 1 or bit 0 set changes no register and leaves `host_rdata` unchanged.
- R2: Own-ID and target-ID keep write bits [2:0]. Data keeps [7:0]. Sync-mode keeps [1:0], where 0 means asynchronous and any other value means synchronous. Diag, control and diag-control keep all 16 bits. Detect-status reads zero and ignores writes.
- R3: On a write to connection-status, a 1 in bits 13, 12, 11, 9, 8, 7 or 3 clears that bit. Otherwise bits in mask 0x3BF7 keep their value, and all other bits take the written value.
- R4: On a write to data-status, a 1 in bits 13, 11, 10, 4 or 3 clears that bit. Otherwise bits in mask 0x0C17 keep their value, and all other bits take the written value.
- R5: Bit 9 (connection summary) is the OR of connection-status bits 13, 12, 11, 10, 7 and 3. Bit 8 (data summary) is the OR of data-status bits 11, 10, 4 and 3. Both bits appear in both status registers.
- R6: `irq` is high exactly while control bit 0 is set and either summary bit is set.
- R7: Command bit 10 (disconnect) clears connected (connection-status bit 2) and selecting (bit 1). It sets state-change (bit 3) only if a selection had been won since the last disconnect or select. The command bit self-clears.
- R8: Command bit 8 (select) self-clears, sets selecting and drops the connected state. An `evt_sel_won` pulse sets connected and state-change, clears selecting and marks the block connected.
- R9: A transfer (command bit 7) fires only when all of these hold: command bit 15 is clear, command [6:4] equals connection-status [6:4], command [1:0] equals data-status [1:0], and selecting is clear. Firing clears command bit 7 and sets data-status bit 4. Otherwise the command stays pending.
- R10: Command bit 14 (reset request) is never stored.
- R11: Data-status bits [2:0] increment modulo 8 once every 16 clock cycles, and writes never change them.
- R12: After reset every register reads zero (apart from the counter field) and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 7 | Byte offset of the access |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data, valid the cycle after `host_rd` |
| evt_cstat_set | input | 16 | One-cycle set mask for connection-status |
| evt_dstat_set | input | 16 | One-cycle set mask for data-status |
| evt_sel_won | input | 1 | Pulse: the target answered the selection |
| irq | output | 1 | Level interrupt |

## Verification
The bench sweeps the status registers with several write patterns over fully set read-only bits. It compares each result with a bit-by-bit model of the clear, keep and take rules. A design that mixed up the masks would either lose read-only state or leave cleared bits standing. The bench holds a transfer pending while selecting is set, while the phase differs, and while the DMA bit is set, each for longer than a full counter period. A gate that ignored any one of these conditions would complete the transfer early. It runs disconnect both after a won selection and again with no connection, so a state-change bit raised without a prior connection shows up. Misaligned reads must leave the previous read data in place, and a block that decoded them would overwrite it.

// File: rtl/scsi_regs_pkg.sv
package scsi_regs_pkg;
  parameter int ADDR_W    = 7;
  parameter int WORD_W    = 16;
  parameter int ID_W      = 3;
  parameter int BYTE_W    = 8;
  parameter int MODE_W    = 2;
  parameter int CNT_W     = 3;
  parameter int PH_LSB    = 4;
  parameter int PH_W      = 3;
  parameter int PHL_W     = 2;

  // status bit positions
  parameter int B_CI      = 9;
  parameter int B_DI      = 8;
  parameter int B_SCH     = 3;
  parameter int B_CON     = 2;
  parameter int B_SIP     = 1;
  parameter int B_TBE     = 4;
  parameter int B_IE      = 0;
  // command bit positions
  parameter int C_DMA     = 15;
  parameter int C_RSTREQ  = 14;
  parameter int C_DISCON  = 10;
  parameter int C_SELECT  = 8;
  parameter int C_XFER    = 7;

  parameter logic [WORD_W-1:0] CST_W1C = 16'h3B88;
  parameter logic [WORD_W-1:0] CST_RO  = 16'h3BF7;
  parameter logic [WORD_W-1:0] DST_W1C = 16'h2C18;
  parameter logic [WORD_W-1:0] DST_RO  = 16'h0C17;
  parameter logic [WORD_W-1:0] CST_SRC = 16'h3C88;
  parameter logic [WORD_W-1:0] DST_SRC = 16'h0C18;

  parameter logic [ADDR_W-1:0] OFS_DIAG  = 7'h00;
  parameter logic [ADDR_W-1:0] OFS_CTRL  = 7'h0C;
  parameter logic [ADDR_W-1:0] OFS_OWNID = 7'h10;
  parameter logic [ADDR_W-1:0] OFS_TGTID = 7'h14;
  parameter logic [ADDR_W-1:0] OFS_DET   = 7'h18;
  parameter logic [ADDR_W-1:0] OFS_DATA  = 7'h20;
  parameter logic [ADDR_W-1:0] OFS_MODE  = 7'h24;
  parameter logic [ADDR_W-1:0] OFS_CST   = 7'h48;
  parameter logic [ADDR_W-1:0] OFS_DST   = 7'h4C;
  parameter logic [ADDR_W-1:0] OFS_CMD   = 7'h50;
  parameter logic [ADDR_W-1:0] OFS_DCTL  = 7'h54;

  typedef struct packed {
    logic [WORD_W-1:0] diag;
    logic [WORD_W-1:0] ctrl;
    logic [ID_W-1:0]   own_id;
    logic [ID_W-1:0]   tgt_id;
    logic [BYTE_W-1:0] data;
    logic [MODE_W-1:0] mode;
    logic [WORD_W-1:0] cst;
    logic [WORD_W-1:0] dst;
    logic [WORD_W-1:0] cmd;
    logic [WORD_W-1:0] dctl;
  } regs_t;

  // clear-on-one, keep read-only, take the rest
  function automatic logic [WORD_W-1:0] status_merge(
    input logic [WORD_W-1:0] old, input logic [WORD_W-1:0] wd,
    input logic [WORD_W-1:0] w1c, input logic [WORD_W-1:0] ro);
    logic [WORD_W-1:0] kept;
    logic [WORD_W-1:0] taken;
    kept  = old & ~(wd & w1c);
    taken = wd & ~w1c;
    return (taken & ~ro) | (kept & ro);
  endfunction

  function automatic logic any_src(input logic [WORD_W-1:0] v,
                                   input logic [WORD_W-1:0] src);
    return |(v & src);
  endfunction

  function automatic logic [WORD_W-1:0] read_word(input regs_t r,
                                                  input logic [ADDR_W-1:0] a);
    logic [WORD_W-1:0] v;
    v = '0;
    case (a)
      OFS_DIAG:  v = r.diag;
      OFS_CTRL:  v = r.ctrl;
      OFS_OWNID: v = WORD_W'(r.own_id);
      OFS_TGTID: v = WORD_W'(r.tgt_id);
      OFS_DATA:  v = WORD_W'(r.data);
      OFS_MODE:  v = WORD_W'(r.mode);
      OFS_CST:   v = r.cst;
      OFS_DST:   v = r.dst;
      OFS_CMD:   v = r.cmd;
      OFS_DCTL:  v = r.dctl;
      default:   v = '0;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/scsi_reg_write.sv
module scsi_reg_write
  import scsi_regs_pkg::*;
(
  input  regs_t                   cur_i,
  input  logic                    wr_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [WORD_W-1:0]       wdata_i,
  output regs_t                   nxt_o,
  output logic                    wr_ok_o
);
  localparam int LOW_W = 2;

  assign wr_ok_o = wr_i && (addr_i[LOW_W-1:0] == '0);

  always_comb begin
    nxt_o = cur_i;
    if (wr_ok_o) begin
      case (addr_i)
        OFS_DIAG:  nxt_o.diag   = wdata_i;
        OFS_CTRL:  nxt_o.ctrl   = wdata_i;
        OFS_OWNID: nxt_o.own_id = wdata_i[ID_W-1:0];
        OFS_TGTID: nxt_o.tgt_id = wdata_i[ID_W-1:0];
        OFS_DATA:  nxt_o.data   = wdata_i[BYTE_W-1:0];
        OFS_MODE:  nxt_o.mode   = wdata_i[MODE_W-1:0];
        OFS_CST:   nxt_o.cst    = status_merge(cur_i.cst, wdata_i, CST_W1C, CST_RO);
        OFS_DST:   nxt_o.dst    = status_merge(cur_i.dst, wdata_i, DST_W1C, DST_RO);
        OFS_CMD: begin
          nxt_o.cmd = wdata_i;
          nxt_o.cmd[C_RSTREQ] = 1'b0;
        end
        OFS_DCTL:  nxt_o.dctl   = wdata_i;
        default:   nxt_o = cur_i;
      endcase
    end
  end
endmodule

// File: rtl/scsi_tick_gen.sv
module scsi_tick_gen #(
  parameter int TICK_LOG2 = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int DW = (TICK_LOG2 < 1) ? 1 : TICK_LOG2;

  logic [DW-1:0] div_q;

  always_ff @(posedge clk) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_q + 1'b1;
  end

  generate
    if (TICK_LOG2 == 0) begin : g_every
      assign tick_o = 1'b1;
    end else begin : g_div
      assign tick_o = &div_q;
      // ticks are never back to back when divided
      assert_tick_spacing_R11: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/scsi_cmd_engine.sv
module scsi_cmd_engine
  import scsi_regs_pkg::*;
(
  input  regs_t             regs_i,
  input  logic              linked_i,
  input  logic              tick_i,
  input  logic [WORD_W-1:0] cst_set_i,
  input  logic [WORD_W-1:0] dst_set_i,
  input  logic              sel_won_i,
  output regs_t             regs_o,
  output logic              linked_o,
  output logic              disc_fire_o,
  output logic              sel_fire_o,
  output logic              xfer_fire_o
);
  logic ph_hi_eq, ph_lo_eq;
  logic ci, di;

  always_comb begin
    regs_o   = regs_i;
    linked_o = linked_i;

    // bus-side events
    regs_o.cst = regs_o.cst | cst_set_i;
    regs_o.dst = regs_o.dst | dst_set_i;
    if (sel_won_i) begin
      regs_o.cst[B_CON] = 1'b1;
      regs_o.cst[B_SCH] = 1'b1;
      regs_o.cst[B_SIP] = 1'b0;
      linked_o = 1'b1;
    end
    if (tick_i) regs_o.dst[CNT_W-1:0] = regs_o.dst[CNT_W-1:0] + 1'b1;

    // disconnect
    disc_fire_o = regs_o.cmd[C_DISCON];
    if (disc_fire_o) begin
      regs_o.cst[B_CON] = 1'b0;
      if (linked_o) begin
        regs_o.cst[B_SCH] = 1'b1;
        linked_o = 1'b0;
      end
      regs_o.cst[B_SIP] = 1'b0;
      regs_o.cmd[C_DISCON] = 1'b0;
    end

    // select
    sel_fire_o = regs_o.cmd[C_SELECT];
    if (sel_fire_o) begin
      regs_o.cmd[C_SELECT] = 1'b0;
      regs_o.cst[B_SIP] = 1'b1;
      linked_o = 1'b0;
    end

    // programmed-I/O transfer
    ph_hi_eq = regs_o.cmd[PH_LSB +: PH_W] == regs_o.cst[PH_LSB +: PH_W];
    ph_lo_eq = regs_o.cmd[PHL_W-1:0] == regs_o.dst[PHL_W-1:0];
    xfer_fire_o = regs_o.cmd[C_XFER] && !regs_o.cmd[C_DMA] && ph_hi_eq && ph_lo_eq
                  && !regs_o.cst[B_SIP];
    if (xfer_fire_o) begin
      regs_o.cmd[C_XFER] = 1'b0;
      regs_o.dst[B_TBE]  = 1'b1;
    end

    // summaries mirrored into both status registers
    ci = any_src(regs_o.cst, CST_SRC);
    di = any_src(regs_o.dst, DST_SRC);
    regs_o.cst[B_CI] = ci;
    regs_o.cst[B_DI] = di;
    regs_o.dst[B_CI] = ci;
    regs_o.dst[B_DI] = di;
  end
endmodule

// File: rtl/scsi_host_regs.sv
module scsi_host_regs
  import scsi_regs_pkg::*;
#(
  parameter int TICK_LOG2 = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [6:0]        host_addr,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [15:0]       host_wdata,
  output logic [15:0]       host_rdata,
  input  logic [15:0]       evt_cstat_set,
  input  logic [15:0]       evt_dstat_set,
  input  logic              evt_sel_won,
  output logic              irq
);
  localparam int LOW_W = 2;

  regs_t regs_q, regs_wr, regs_d;
  logic  linked_q, linked_d;
  logic  wr_ok, tick;
  logic  disc_fire, sel_fire, xfer_fire;
  logic  rd_ok;
  logic [WORD_W-1:0] rdata_q;

  scsi_reg_write u_wr (
    .cur_i   (regs_q),
    .wr_i    (host_wr),
    .addr_i  (host_addr),
    .wdata_i (host_wdata),
    .nxt_o   (regs_wr),
    .wr_ok_o (wr_ok)
  );

  scsi_tick_gen #(.TICK_LOG2(TICK_LOG2)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_o (tick)
  );

  scsi_cmd_engine u_cmd (
    .regs_i      (regs_wr),
    .linked_i    (linked_q),
    .tick_i      (tick),
    .cst_set_i   (evt_cstat_set),
    .dst_set_i   (evt_dstat_set),
    .sel_won_i   (evt_sel_won),
    .regs_o      (regs_d),
    .linked_o    (linked_d),
    .disc_fire_o (disc_fire),
    .sel_fire_o  (sel_fire),
    .xfer_fire_o (xfer_fire)
  );

  assign rd_ok = host_rd && (host_addr[LOW_W-1:0] == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      regs_q   <= '0;
      linked_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      regs_q   <= regs_d;
      linked_q <= linked_d;
      if (rd_ok) rdata_q <= read_word(regs_q, host_addr);
    end
  end

  assign host_rdata = rdata_q;
  assign irq = regs_q.ctrl[B_IE] && (regs_q.cst[B_CI] || regs_q.cst[B_DI]);

  // misaligned access leaves configuration registers alone
  assert_misaligned_wr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr[1:0] != 2'b00 && !evt_sel_won && evt_cstat_set == '0)
      |=> (regs_q.ctrl == $past(regs_q.ctrl) && regs_q.own_id == $past(regs_q.own_id)
           && regs_q.cmd == $past(regs_q.cmd)));

  assert_rd_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_ok |=> $stable(host_rdata));

  assert_irq_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && host_addr == OFS_CTRL && !host_wdata[B_IE]) |=> !irq);

  assert_discon_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && host_addr == OFS_CMD && host_wdata[C_DISCON] && !host_wdata[C_SELECT])
      |=> (!regs_q.cst[B_CON] && !regs_q.cst[B_SIP] && !regs_q.cmd[C_DISCON]));

  assert_select_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && host_addr == OFS_CMD && host_wdata[C_SELECT])
      |=> (regs_q.cst[B_SIP] && !regs_q.cmd[C_SELECT]));

  assert_xfer_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_fire |-> !regs_wr.cmd[C_DMA]);

  assert_rstreq_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !regs_q.cmd[C_RSTREQ]);

  assert_cnt_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && evt_dstat_set[CNT_W-1:0] == '0)
      |=> regs_q.dst[CNT_W-1:0] == $past(regs_q.dst[CNT_W-1:0]) + 1'b1);

  assert_sel_disc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (disc_fire || sel_fire) |=> !linked_q);
endmodule

// File: tb/test_scsi_host_regs.sv
module test_scsi_host_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  host_addr = '0;
  logic        host_wr = 1'b0;
  logic        host_rd = 1'b0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic [15:0] evt_cstat_set = '0;
  logic [15:0] evt_dstat_set = '0;
  logic        evt_sel_won = 1'b0;
  logic        irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // 8-unit period: 125 MHz at 1 ns per unit
  always #4 clk = ~clk;

  scsi_host_regs i_scsi_host_regs (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .evt_cstat_set(evt_cstat_set), .evt_dstat_set(evt_dstat_set),
    .evt_sel_won(evt_sel_won), .irq(irq)
  );

  localparam logic [15:0] CW1C = 16'h3B88, CRO = 16'h3BF7;
  localparam logic [15:0] DW1C = 16'h2C18, DRO = 16'h0C17;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [6:0] a, input logic [15:0] d);
    @(negedge clk); host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [15:0] d);
    @(negedge clk); host_addr = a; host_rd = 1'b1;
    @(negedge clk); host_rd = 1'b0; d = host_rdata;
  endtask

  task automatic pulse(input logic [15:0] cs, input logic [15:0] ds, input logic sw);
    @(negedge clk); evt_cstat_set = cs; evt_dstat_set = ds; evt_sel_won = sw;
    @(negedge clk); evt_cstat_set = '0; evt_dstat_set = '0; evt_sel_won = 1'b0;
  endtask

  // bit-by-bit statement of the status write rules
  function automatic logic [15:0] rule(input logic [15:0] old, input logic [15:0] w,
                                       input logic [15:0] c1, input logic [15:0] ro);
    logic [15:0] e;
    for (int b = 0; b < 16; b++) begin
      if (c1[b] && w[b]) e[b] = 1'b0;
      else if (ro[b])    e[b] = old[b];
      else               e[b] = w[b];
    end
    return e;
  endfunction

  function automatic logic csum(input logic [15:0] v);
    return v[13] | v[12] | v[11] | v[10] | v[7] | v[3];
  endfunction
  function automatic logic dsum(input logic [15:0] v);
    return v[11] | v[10] | v[4] | v[3];
  endfunction

  // poll command until transfer bit clears; returns last value
  task automatic poll_cmd(input int n, output logic [15:0] v);
    for (int i = 0; i < n; i++) begin
      rd(7'h50, v);
      if (!v[7]) break;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, v2, e, pats[4];
    pats[0] = 16'hFFFF; pats[1] = 16'h0000; pats[2] = 16'hA5A5; pats[3] = 16'h5A5A;

    // R12: reset state across the whole map
    do_reset();
    check("R12 irq", {15'd0, irq}, 16'h0);
    for (int a = 0; a < 128; a += 4) begin
      rd(7'(a), v);
      if (a == 'h4C) v = v & 16'hFFF8;
      check("R12 reset read", v, 16'h0);
    end

    // R2: field widths
    wr(7'h10, 16'hFFFF); rd(7'h10, v); check("R2 own-id", v, 16'h0007);
    wr(7'h14, 16'hFFF9); rd(7'h14, v); check("R2 target-id", v, 16'h0001);
    wr(7'h20, 16'hABCD); rd(7'h20, v); check("R2 data", v, 16'h00CD);
    wr(7'h24, 16'hFFFE); rd(7'h24, v); check("R2 sync-mode", v, 16'h0002);
    wr(7'h18, 16'hFFFF); rd(7'h18, v); check("R2 detect ro", v, 16'h0000);
    wr(7'h00, 16'h1234); rd(7'h00, v); check("R2 diag", v, 16'h1234);
    wr(7'h54, 16'hBEEF); rd(7'h54, v); check("R2 diag-ctl", v, 16'hBEEF);
    wr(7'h0C, 16'hFFFE); rd(7'h0C, v); check("R2 control", v, 16'hFFFE);

    // R1: unmapped and misaligned
    wr(7'h30, 16'hFFFF); rd(7'h30, v); check("R1 unmapped", v, 16'h0000);
    wr(7'h10, 16'h0005);
    wr(7'h11, 16'h0002); rd(7'h10, v); check("R1 misaligned write", v, 16'h0005);
    rd(7'h13, v); check("R1 misaligned read holds", v, 16'h0005);
    rd(7'h22, v); check("R1 misaligned read holds 2", v, 16'h0005);

    // R3 and R5: connection-status write rules
    foreach (pats[k]) begin
      do_reset();
      pulse(16'hFCFF, 16'h0000, 1'b0);
      rd(7'h48, v); check("R5 ci set after strobe", v, 16'hFEFF);
      e = rule(16'hFEFF, pats[k], CW1C, CRO);
      e[9] = csum(e); e[8] = 1'b0;
      wr(7'h48, pats[k]); rd(7'h48, v);
      check("R3 cstat merge", v, e);
    end

    // R4 and R5: data-status write rules
    foreach (pats[k]) begin
      do_reset();
      pulse(16'h0000, 16'hFCF8, 1'b0);
      rd(7'h4C, v); check("R5 di mirrored", v & 16'hFFF8, 16'hFDF8);
      rd(7'h48, v); check("R5 di in cstat", v, 16'h0100);
      e = rule(16'hFDF8, pats[k], DW1C, DRO);
      e[8] = dsum(e); e[9] = 1'b0;
      wr(7'h4C, pats[k]); rd(7'h4C, v);
      check("R4 dstat merge", v & 16'hFFF8, e & 16'hFFF8);
    end

    // R6: interrupt gating
    do_reset();
    wr(7'h0C, 16'h0001);
    pulse(16'h0080, 16'h0000, 1'b0);
    check("R6 irq on", {15'd0, irq}, 16'h1);
    wr(7'h48, 16'h0080);
    check("R6 irq cleared", {15'd0, irq}, 16'h0);
    wr(7'h0C, 16'h0000);
    pulse(16'h0000, 16'h0400, 1'b0);
    check("R6 irq masked", {15'd0, irq}, 16'h0);
    wr(7'h0C, 16'h0001);
    check("R6 irq enabled", {15'd0, irq}, 16'h1);

    // R8 and R7: select, won, disconnect
    do_reset();
    wr(7'h50, 16'h0100);
    rd(7'h50, v); check("R8 select self-clears", v, 16'h0000);
    rd(7'h48, v); check("R8 selecting", v, 16'h0002);
    pulse(16'h0000, 16'h0000, 1'b1);
    rd(7'h48, v); check("R8 selection won", v, 16'h020C);
    wr(7'h50, 16'h0400);
    rd(7'h48, v); check("R7 disconnect connected", v, 16'h0208);
    rd(7'h50, v); check("R7 disconnect self-clears", v, 16'h0000);
    wr(7'h48, 16'h0008);
    rd(7'h48, v); check("R7 state-change cleared", v, 16'h0000);
    wr(7'h50, 16'h0400);
    rd(7'h48, v); check("R7 disconnect idle no change", v, 16'h0000);

    // R9: transfer gating
    pulse(16'h0050, 16'h0000, 1'b0);
    wr(7'h50, 16'h0100);
    wr(7'h50, 16'h00D2);
    poll_cmd(70, v); check("R9 blocked while selecting", v, 16'h00D2);
    wr(7'h50, 16'h04D2);
    poll_cmd(80, v); check("R9 transfer completes", v, 16'h0052);
    rd(7'h4C, v); check("R9 tbe set", v & 16'h0010, 16'h0010);
    rd(7'h48, v); check("R9 di summary", v & 16'h0100, 16'h0100);
    wr(7'h4C, 16'h0010);
    rd(7'h4C, v); check("R9 tbe cleared", v & 16'h0010, 16'h0000);
    wr(7'h50, 16'h00B2);
    poll_cmd(70, v); check("R9 phase mismatch pending", v, 16'h00B2);
    wr(7'h50, 16'h80D2);
    poll_cmd(70, v); check("R9 dma pending", v, 16'h80D2);

    // R10: reset request not stored
    wr(7'h50, 16'h4001);
    rd(7'h50, v); check("R10 reset request dropped", v, 16'h0001);

    // R11: counter cadence and read-only
    rd(7'h4C, v);
    repeat (14) @(negedge clk);
    rd(7'h4C, v2);
    check("R11 counter step", {13'd0, v2[2:0]}, {13'd0, 3'(v[2:0] + 3'd1)});
    rd(7'h4C, v);
    wr(7'h4C, 16'h0007);
    repeat (10) @(negedge clk);
    rd(7'h4C, v2);
    check("R11 counter not written", {13'd0, v2[2:0]}, {13'd0, 3'(v[2:0] + 3'd1)});

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule